// File: doc/BRIEF.md
# Flash Request Chunking Engine

This block sits between a host that asks for large flash operations and a sequencer that can only execute one bounded cycle at a time. A host request names an operation (read, write or erase), a start byte address and a byte count. The engine breaks it into a series of legal sequencer cycles and issues them strictly one after another. Before each cycle it waits for the sequencer to report idle, and after each cycle it waits for a done or error indication. Only cycle type, address and length go out; payload bytes travel elsewhere.

Read and write requests are cut so that no piece exceeds the data buffer and no piece straddles a flash page. Erase requests must be sector aligned. They are then covered with large 64 KiB blocks wherever the address and the remaining count allow, and with 4 KiB sectors everywhere else. The request ends with one status pulse: success, timeout, hardware error or argument error. Any failure ends the request at once.

Top module: `flash_chunker`

## Requirements
- R1: After reset, and between requests, `req_ready_o` is high while `cmd_go_o` and `rsp_valid_o` are low.
- R2: Request operation codes are 0 read, 1 write, 2 erase. For reads and writes, `cmd_op_o` is 0 for read and 1 for write. Each piece has a length equal to the smallest of three values: the remaining byte count, BUF_BYTES (default 64), and the distance from the piece address to the next 256-byte page boundary.
- R3: Each piece starts where the previous one ended. The remaining count shrinks by each piece length. When it reaches zero, the request ends with status 0 (success).
- R4: An erase whose address or byte count is not a multiple of 4096 ends with status 3 (argument error) and issues no cycle. Operation code 3 is answered the same way.
- R5: Each erase step uses `cmd_op_o` = 3 with length 65536 when the current address is a multiple of 65536 and at least 65536 bytes remain. Otherwise it uses `cmd_op_o` = 2 with length 4096.
- R6: A read or write with zero length ends with status 0 in the cycle after it is accepted, with no cycle issued.
- R7: `cmd_go_o` is a one-cycle pulse. It is raised only if `seq_busy_i` was low at the previous clock edge, and no further pulse follows until done or error is reported.
- R8: An error reported for any piece ends the request with status 2 (hardware error), and no further piece is issued.
- R9: If the idle wait or the done wait lasts `tmo_limit_i`+1 cycles without being satisfied, the request ends with status 1 (timeout). With a sequencer that stays busy, `rsp_valid_o` rises `tmo_limit_i`+2 cycles after the accepting edge.
- R10: `rsp_valid_o` is a one-cycle pulse. `req_ready_o` stays low from acceptance until after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Engine can take a request |
| req_op_i | input | 2 | 0 read, 1 write, 2 erase, 3 invalid |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count |
| tmo_limit_i | input | TMO_W | Wait limit in cycles |
| cmd_go_o | output | 1 | Start pulse for one sequencer cycle |
| cmd_op_o | output | 2 | 0 read, 1 write, 2 erase 4 KiB, 3 erase 64 KiB |
| cmd_addr_o | output | ADDR_W | Cycle start address |
| cmd_len_o | output | LEN_W | Cycle byte count |
| seq_busy_i | input | 1 | Sequencer cycle in progress |
| seq_done_i | input | 1 | Current cycle finished cleanly |
| seq_err_i | input | 1 | Current cycle failed |
| rsp_valid_o | output | 1 | Request finished |
| rsp_status_o | output | 2 | 0 ok, 1 timeout, 2 hardware error, 3 argument error |

## Verification
Reads are tried from a page-aligned start, where only the buffer size and the tail limit the pieces, and from an offset just below a page boundary, where the first piece is a short page remainder. A write starting mid-page with a long count separates the page limit from the buffer limit. Erases that begin just below a 64 KiB boundary, and aligned erases shorter than 64 KiB, show whether the large block is chosen by alignment and by remaining size together. Misaligned erases, zero-length reads, an injected error, a sequencer stuck busy and a cycle that never completes cover the early-exit paths and their statuses and timing.

// File: rtl/fchunk_pkg.sv
package fchunk_pkg;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_ERASE = 2'd2, REQ_BAD = 2'd3} req_op_e;
  typedef enum logic [1:0] {CYC_RD = 2'd0, CYC_WR = 2'd1, CYC_ER_SM = 2'd2, CYC_ER_LG = 2'd3} cyc_e;
  typedef enum logic [1:0] {RSP_OK = 2'd0, RSP_TMO = 2'd1, RSP_HWERR = 2'd2, RSP_ARGERR = 2'd3} rsp_e;
  typedef enum logic [2:0] {S_IDLE, S_WAIT_IDLE, S_ISSUE, S_WAIT_DONE, S_RESP} state_e;
endpackage

// File: rtl/fchunk_rw_len.sv
module fchunk_rw_len #(
  parameter int LEN_W      = 24,
  parameter int BUF_BYTES  = 64,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
  input  logic [PAGE_W-1:0] addr_lo_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] BUF_L  = LEN_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

  logic [LEN_W-1:0] to_page, cap;

  always_comb begin
    to_page = PAGE_L - {{(LEN_W-PAGE_W){1'b0}}, addr_lo_i};
    cap     = (rem_i < BUF_L) ? rem_i : BUF_L;
    len_o   = (to_page < cap) ? to_page : cap;
  end
endmodule

// File: rtl/fchunk_erase_step.sv
module fchunk_erase_step #(
  parameter int LEN_W       = 24,
  parameter int SMALL_ERASE = 4096,
  parameter int LARGE_ERASE = 65536,
  localparam int LG_W       = $clog2(LARGE_ERASE)
) (
  input  logic [LG_W-1:0]  addr_lo_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic             large_o,
  output logic [LEN_W-1:0] step_o
);
  always_comb begin
    large_o = (addr_lo_i == '0) && (rem_i >= LEN_W'(LARGE_ERASE));
    step_o  = large_o ? LEN_W'(LARGE_ERASE) : LEN_W'(SMALL_ERASE);
  end
endmodule

// File: rtl/fchunk_wait_timer.sv
module fchunk_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (run_i && cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/flash_chunker.sv
module flash_chunker
  import fchunk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 24,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int SMALL_ERASE = 4096,
  parameter int LARGE_ERASE = 65536,
  parameter int TMO_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              cmd_go_o,
  output logic [1:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  input  logic              seq_busy_i,
  input  logic              seq_done_i,
  input  logic              seq_err_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int SM_W   = $clog2(SMALL_ERASE);
  localparam int LG_W   = $clog2(LARGE_ERASE);

  state_e           state_q, state_d;
  req_op_e          op_q, req_op;
  rsp_e             status_q, status_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  cyc_e              cyc_q;
  logic [ADDR_W-1:0] caddr_q;
  logic [LEN_W-1:0]  clen_q;

  logic [LEN_W-1:0] rw_len, er_len, next_len;
  logic             er_large, tmo_hit, arg_bad;
  cyc_e             next_cyc;

  assign req_op = req_op_e'(req_op_i);

  fchunk_rw_len #(
    .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_rw_len (
    .addr_lo_i(addr_q[PAGE_W-1:0]),
    .rem_i    (rem_q),
    .len_o    (rw_len)
  );

  fchunk_erase_step #(
    .LEN_W(LEN_W), .SMALL_ERASE(SMALL_ERASE), .LARGE_ERASE(LARGE_ERASE)
  ) u_erase_step (
    .addr_lo_i(addr_q[LG_W-1:0]),
    .rem_i    (rem_q),
    .large_o  (er_large),
    .step_o   (er_len)
  );

  fchunk_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != state_d),
    .run_i    ((state_q == S_WAIT_IDLE) || (state_q == S_WAIT_DONE)),
    .limit_i  (tmo_limit_i),
    .expired_o(tmo_hit)
  );

  always_comb begin
    if (op_q == REQ_ERASE) begin
      next_len = er_len;
      next_cyc = er_large ? CYC_ER_LG : CYC_ER_SM;
    end else begin
      next_len = rw_len;
      next_cyc = (op_q == REQ_WR) ? CYC_WR : CYC_RD;
    end
  end

  // erase must be sector aligned in both start and size; code 3 is never legal
  assign arg_bad = (req_op == REQ_BAD) ||
                   ((req_op == REQ_ERASE) &&
                    ((req_addr_i[SM_W-1:0] != '0) || (req_len_i[SM_W-1:0] != '0)));

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        if (arg_bad) begin
          state_d = S_RESP; status_d = RSP_ARGERR;
        end else if (req_len_i == '0) begin
          state_d = S_RESP; status_d = RSP_OK;
        end else begin
          state_d = S_WAIT_IDLE; status_d = RSP_OK;
        end
      end
      S_WAIT_IDLE: begin
        if (!seq_busy_i)  state_d = S_ISSUE;
        else if (tmo_hit) begin state_d = S_RESP; status_d = RSP_TMO; end
      end
      S_ISSUE: state_d = S_WAIT_DONE;
      S_WAIT_DONE: begin
        if (seq_err_i) begin
          state_d = S_RESP; status_d = RSP_HWERR;
        end else if (seq_done_i) begin
          state_d = (rem_q == clen_q) ? S_RESP : S_WAIT_IDLE;
        end else if (tmo_hit) begin
          state_d = S_RESP; status_d = RSP_TMO;
        end
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= RSP_OK;
      op_q     <= REQ_RD;
      addr_q   <= '0;
      rem_q    <= '0;
      cyc_q    <= CYC_RD;
      caddr_q  <= '0;
      clen_q   <= '0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (state_q == S_IDLE && req_valid_i) begin
        op_q   <= req_op;
        addr_q <= req_addr_i;
        rem_q  <= req_len_i;
      end
      if (state_q == S_WAIT_IDLE && !seq_busy_i) begin
        cyc_q   <= next_cyc;
        caddr_q <= addr_q;
        clen_q  <= next_len;
      end
      if (state_q == S_WAIT_DONE && !seq_err_i && seq_done_i) begin
        addr_q <= addr_q + {{(ADDR_W-LEN_W){1'b0}}, clen_q};
        rem_q  <= rem_q - clen_q;
      end
    end
  end

  assign req_ready_o  = (state_q == S_IDLE);
  assign cmd_go_o     = (state_q == S_ISSUE);
  assign cmd_op_o     = cyc_q;
  assign cmd_addr_o   = caddr_q;
  assign cmd_len_o    = clen_q;
  assign rsp_valid_o  = (state_q == S_RESP);
  assign rsp_status_o = status_q;
endmodule

// File: rtl/fchunk_checker.sv
module fchunk_checker #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 24,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int SMALL_ERASE = 4096,
  parameter int LARGE_ERASE = 65536
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              cmd_go_o,
  input logic [1:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [LEN_W-1:0]  cmd_len_o,
  input logic              seq_busy_i,
  input logic              rsp_valid_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int SM_W   = $clog2(SMALL_ERASE);
  localparam int LG_W   = $clog2(LARGE_ERASE);

  logic [LEN_W-1:0] page_end;
  assign page_end = {{(LEN_W-PAGE_W){1'b0}}, cmd_addr_o[PAGE_W-1:0]} + cmd_len_o;

  AST_GO_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go_o |-> !$past(seq_busy_i)); // R7
  AST_GO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go_o |=> !cmd_go_o); // R7
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R10
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cmd_go_o && !rsp_valid_o)); // R10
  AST_RW_PIECE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go_o && !cmd_op_o[1]) |->
      (cmd_len_o != '0 && cmd_len_o <= LEN_W'(BUF_BYTES) && page_end <= LEN_W'(PAGE_BYTES))); // R2
  AST_ERASE_LG_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go_o && cmd_op_o == 2'd3) |->
      (cmd_addr_o[LG_W-1:0] == '0 && cmd_len_o == LEN_W'(LARGE_ERASE))); // R5
  AST_ERASE_SM_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go_o && cmd_op_o == 2'd2) |->
      (cmd_addr_o[SM_W-1:0] == '0 && cmd_len_o == LEN_W'(SMALL_ERASE))); // R5
endmodule

bind flash_chunker fchunk_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .PAGE_BYTES(PAGE_BYTES),
  .SMALL_ERASE(SMALL_ERASE), .LARGE_ERASE(LARGE_ERASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .cmd_go_o(cmd_go_o),
  .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o), .cmd_len_o(cmd_len_o),
  .seq_busy_i(seq_busy_i), .rsp_valid_o(rsp_valid_o)
);

// File: tb/flash_chunker_test.sv
module flash_chunker_test;
  localparam int ADDR_W = 32, LEN_W = 24, TMO_W = 16;
  localparam int BUF = 64, PAGE = 256, LAT = 3, LIMIT = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [1:0] req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic [TMO_W-1:0] tmo_limit_i = TMO_W'(LIMIT);
  logic cmd_go_o;
  logic [1:0] cmd_op_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [LEN_W-1:0] cmd_len_o;
  logic seq_busy_r = 1'b0, stuck_busy = 1'b0, seq_done_i = 1'b0, seq_err_i = 1'b0;
  logic seq_busy_i;
  logic rsp_valid_o;
  logic [1:0] rsp_status_o;

  assign seq_busy_i = seq_busy_r | stuck_busy;

  always #5 clk_i = ~clk_i;

  flash_chunker uut (.*);

  int errors = 0, checks = 0;
  int exp_op[$], exp_addr[$], exp_len[$];
  int err_at = -1, go_idx = 0, lat_left = 0;
  bit hang = 0, finished = 0;
  string cur_req = "";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: list of cycles a request must produce
  task automatic expect_cycles(int op, int addr, int len);
    int a = addr, r = len, n;
    exp_op.delete(); exp_addr.delete(); exp_len.delete();
    while (r > 0) begin
      if (op == 2) begin
        if ((a % 65536) == 0 && r >= 65536) begin n = 65536; exp_op.push_back(3); end
        else begin n = 4096; exp_op.push_back(2); end
      end else begin
        n = r;
        if (n > BUF) n = BUF;
        if (n > PAGE - (a % PAGE)) n = PAGE - (a % PAGE);
        exp_op.push_back(op);
      end
      exp_addr.push_back(a); exp_len.push_back(n);
      a += n; r -= n;
    end
  endtask

  // sequencer model and command monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (cmd_go_o) begin
        check(!seq_busy_i, "R7", "go while busy", 1, 0);
        if (exp_op.size() == 0) begin
          check(0, cur_req, "unexpected cycle addr", longint'(cmd_addr_o), -1);
        end else begin
          check(int'(cmd_op_o) == exp_op[0], cur_req, "cycle op", cmd_op_o, exp_op[0]);
          check(int'(cmd_addr_o) == exp_addr[0], cur_req, "cycle addr", cmd_addr_o, exp_addr[0]);
          check(int'(cmd_len_o) == exp_len[0], cur_req, "cycle len", cmd_len_o, exp_len[0]);
          void'(exp_op.pop_front()); void'(exp_addr.pop_front()); void'(exp_len.pop_front());
        end
      end
      seq_done_i = 1'b0; seq_err_i = 1'b0;
      if (lat_left > 0) begin
        lat_left--;
        if (lat_left == 0) begin
          seq_busy_r = 1'b0;
          if (go_idx - 1 == err_at) seq_err_i = 1'b1; else seq_done_i = 1'b1;
        end
      end
      if (cmd_go_o) begin
        seq_busy_r = 1'b1;
        lat_left = hang ? 0 : LAT;
        go_idx++;
      end
    end
  end

  task automatic run_req(string req, int op, int addr, int len, int exp_st, int keep, int exp_cyc);
    int cycles = 1;
    cur_req = req;
    expect_cycles(op, addr, len);
    while (exp_op.size() > keep) begin
      void'(exp_op.pop_back()); void'(exp_addr.pop_back()); void'(exp_len.pop_back());
    end
    go_idx = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 2'(op); req_addr_i = ADDR_W'(addr); req_len_i = LEN_W'(len);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) begin
      if (!req_ready_o) ; else check(0, "R10", "ready during request", 1, 0);
      @(negedge clk_i); cycles++;
    end
    check(int'(rsp_status_o) == exp_st, req, "status", rsp_status_o, exp_st);
    check(!req_ready_o, "R10", "ready at response", req_ready_o, 0);
    check(exp_op.size() == 0, req, "cycles missing", exp_op.size(), 0);
    check(go_idx == keep, req, "cycle count", go_idx, keep);
    if (exp_cyc >= 0) check(cycles == exp_cyc, req, "response latency", cycles, exp_cyc);
    @(negedge clk_i);
    check(!rsp_valid_o && req_ready_o, "R10", "pulse/ready after response", rsp_valid_o, 0);
    hang = 0; seq_busy_r = 1'b0; lat_left = 0; stuck_busy = 1'b0; err_at = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !cmd_go_o && !rsp_valid_o, "R1", "idle after reset", req_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && !cmd_go_o && !rsp_valid_o, "R1", "idle out of reset", req_ready_o, 1);

    run_req("R2_aligned_read", 0, 'h1000, 200, 0, 4, -1);
    run_req("R2_offset_read", 0, 'h10F0, 100, 0, 3, -1);
    run_req("R3_midpage_write", 1, 'h20C5, 300, 0, 5, -1);
    run_req("R3_short_read", 0, 'h3000, 5, 0, 1, -1);
    run_req("R6_zero_read", 0, 'h4000, 0, 0, 0, 1);
    run_req("R6_zero_write", 1, 'h4003, 0, 0, 0, 1);
    run_req("R4_erase_addr", 2, 'h1800, 'h1000, 3, 0, 1);
    run_req("R4_erase_len", 2, 'h2000, 'h1100, 3, 0, 1);
    run_req("R4_bad_op", 3, 'h0, 'h1000, 3, 0, 1);
    run_req("R5_erase_mixed", 2, 'hF000, 'h22000, 0, 4, -1);
    run_req("R5_erase_short", 2, 'h40000, 'hF000, 0, 15, -1);
    err_at = 1;
    run_req("R8_error", 0, 'h5000, 150, 2, 2, -1);
    stuck_busy = 1'b1;
    run_req("R9_stuck_busy", 0, 'h6000, 64, 1, 0, LIMIT + 2);
    hang = 1;
    run_req("R9_no_done", 1, 'h7000, 128, 1, 1, -1);
    run_req("R3_after_faults", 1, 'h70FF, 2, 0, 2, -1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule